// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block brings up one Ethernet PHY over a management bus without software help. On a start command it finds the PHY by probing management addresses. It then resets the PHY and takes it out of electrical isolation. It sets the PHY's speed and duplex abilities and restarts auto-negotiation. Last, it waits for negotiation to finish and for the link to come up. Each wait is paced by a millisecond tick and bounded by a timeout budget.

The block does not drive the MDIO pins itself. Every register access goes to an MDIO master through a request/done handshake. The master returns a success flag, and for reads a 16-bit data word. The block stops at the first failure and reports it with an error code. It also reports the PHY address it selected and a set of progress flags.

Top module: `phy_bringup`

## Requirements
- R1: Probing starts at address 0 and walks upward to PHY_SLOTS-1. At each address a status read (register 1) is issued, and only if that succeeds a control read (register 0) follows. The first address where both reads succeed is latched into phy_addr and phy_found is set.
- R2: If no address passes both reads, the run ends with done=1, err_code=1 and phy_found=0.
- R3: Reset writes exactly 16'h8000 (bit 15) to register 0. The block then waits STEP_TICKS ms_tick pulses before each read of register 0, and the reset is finished when a read returns bit 15 clear.
- R4: Each reset poll that finds bit 15 still set uses one step of the budget. At most ceil(BUDGET_TICKS/STEP_TICKS) polls are made. If the budget runs out, the run ends with err_code=3 and timeout=1.
- R5: A failed read while polling for reset ends the run with err_code=2 and timeout=0.
- R6: Once reset clears, register 0 is read and written back with bit 10 (isolate) cleared. After that write, reset_ok is set.
- R7: Configuration then does four read-modify-writes in this order: register 0 with bit 12 (auto-negotiation enable) cleared; register 4 with bits 8..5 set; register 0 with bit 12 set; register 0 with bit 9 (restart) set. The other bits keep their read values. Bit 9 is never polled. A failed read in this phase ends the run with err_code=4.
- R8: The negotiation wait reads register 1 at once and then after every STEP_TICKS ticks, using the same budget rule, until bit 5 is set. On success aneg_done is set. A failed read gives err_code=5; running out of budget gives err_code=6 with timeout=1.
- R9: The link wait starts with a fresh budget and polls register 1 the same way, until bit 2 is set. On success link_up is set and the run ends with done=1 and err_code=0. A failed read gives err_code=7; running out of budget gives err_code=8 with timeout=1.
- R10: mdio_req is held, with its address, write flag and data stable, until mdio_done. It drops in the cycle after mdio_done and stays low for at least one cycle before the next request.
- R11: start is only accepted while busy=0. Accepting it clears all flags and the error code, sets busy and clears done. A start pulse during a run has no effect. The flags always satisfy link_up ⇒ aneg_done ⇒ reset_ok ⇒ phy_found.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (one-cycle pulse) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mdio_req | output | 1 | Access request to the MDIO master |
| mdio_wr | output | 1 | 1 = write access, 0 = read access |
| mdio_phy | output | 5 | PHY address of the access |
| mdio_reg | output | 5 | Register number of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | Access complete (one-cycle pulse) |
| mdio_ok | input | 1 | Access succeeded; sampled together with mdio_done |
| mdio_rdata | input | 16 | Read data; sampled together with mdio_done |
| phy_addr | output | 5 | Selected PHY address |
| phy_found | output | 1 | A PHY answered both probe reads |
| reset_ok | output | 1 | Reset finished and isolate cleared |
| aneg_done | output | 1 | Auto-negotiation complete was seen |
| link_up | output | 1 | Link status was seen |
| timeout | output | 1 | Run ended because a poll budget ran out |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended (success or error) |
| err_code | output | 4 | 0 ok, 1 no PHY, 2/3 reset read/timeout, 4 config read, 5/6 negotiation read/timeout, 7/8 link read/timeout |

## Verification
The checker watches the handshake on every cycle: the request is held and stays stable until done, and it drops afterwards. It also checks the order of the progress flags, that timeout appears only with one of the three timeout codes, that every probe address is in range, and the exact reset and advertisement write values. Several behaviours can only be shown by the bench's scenarios, which use a model PHY. These are the first-qualifying-address choice when a partial responder sits below the real PHY, the order and values of the read-modify-write sequence, the number of polls at each budget edge, and tick-paced delays between polls. The bench also checks that a start pulse during a run is ignored.

// File: rtl/phy_bringup_pkg.sv
`timescale 1ns/1ps
package phy_bringup_pkg;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;

  localparam int B_RESET   = 15;
  localparam int B_ANEN    = 12;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_ANDONE  = 5;
  localparam int B_LINK    = 2;

  localparam logic [15:0] ADV_ABILITY = 16'h01E0;
  localparam int          CFG_STEPS   = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_ST, S_SCAN_CT, S_RST_WR, S_RST_DLY, S_RST_RD,
    S_CFG_RD, S_CFG_WR, S_AN_RD, S_AN_DLY, S_LK_RD, S_LK_DLY
  } state_t;

  typedef enum logic [3:0] {
    E_NONE = 4'd0, E_NO_PHY = 4'd1, E_RST_RD = 4'd2, E_RST_TO = 4'd3,
    E_CFG_RD = 4'd4, E_AN_RD = 4'd5, E_AN_TO = 4'd6, E_LK_RD = 4'd7,
    E_LK_TO = 4'd8
  } err_t;

  typedef struct packed {
    logic [4:0]  regno;
    logic [15:0] set_m;
    logic [15:0] clr_m;
  } rmw_t;

  // step 0 belongs to reset completion, steps 1..4 are configuration
  function automatic rmw_t rmw_step(input logic [2:0] idx);
    rmw_t s;
    s.regno = REG_CTRL;
    s.set_m = '0;
    s.clr_m = '0;
    case (idx)
      3'd0:    s.clr_m = 16'h0001 << B_ISO;
      3'd1:    s.clr_m = 16'h0001 << B_ANEN;
      3'd2:    begin s.regno = REG_ADV; s.set_m = ADV_ABILITY; end
      3'd3:    s.set_m = 16'h0001 << B_ANEN;
      3'd4:    s.set_m = 16'h0001 << B_RESTART;
      default: s.regno = REG_CTRL;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pbu_tick_delay.sv
`timescale 1ns/1ps
module pbu_tick_delay #(
  parameter int STEP_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ms_tick,
  output logic expired
);
  localparam int CW = $clog2(STEP_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STEP_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (ms_tick && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LIMIT);
endmodule

// File: rtl/pbu_budget.sv
`timescale 1ns/1ps
module pbu_budget #(
  parameter int BUDGET_TICKS = 5000,
  parameter int STEP_TICKS   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int BW = $clog2(BUDGET_TICKS + 1);
  localparam logic [BW-1:0] FULL  = BW'(BUDGET_TICKS);
  localparam logic [BW-1:0] STEPV = BW'(STEP_TICKS);

  logic [BW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst)
      remaining <= '0;
    else if (load)
      remaining <= FULL;
    else if (dec && remaining > STEPV)
      remaining <= remaining - STEPV;
  end

  // the poll now under way is the last one the budget pays for
  assign last = (remaining <= STEPV);
endmodule

// File: rtl/phy_bringup.sv
`timescale 1ns/1ps
module phy_bringup
  import phy_bringup_pkg::*;
#(
  parameter int PHY_SLOTS    = 32,
  parameter int STEP_TICKS   = 10,
  parameter int BUDGET_TICKS = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        ms_tick,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic        mdio_ok,
  input  logic [15:0] mdio_rdata,
  output logic [4:0]  phy_addr,
  output logic        phy_found,
  output logic        reset_ok,
  output logic        aneg_done,
  output logic        link_up,
  output logic        timeout,
  output logic        busy,
  output logic        done,
  output logic [3:0]  err_code
);
  localparam logic [4:0] LAST_PHY  = 5'(PHY_SLOTS - 1);
  localparam logic [2:0] LAST_STEP = 3'(CFG_STEPS - 1);

  state_t      state;
  logic [4:0]  cur_phy;
  logic [2:0]  step_idx;
  logic [15:0] rmw_val;
  rmw_t        cur_step;

  logic        is_op, op_wr;
  logic [4:0]  op_reg;
  logic [15:0] op_data;
  logic        op_fin, dly_run, dly_exp;
  logic        bud_load, bud_dec, bud_last;
  logic        abort;
  err_t        abort_code;

  assign cur_step = rmw_step(step_idx);
  assign op_fin   = mdio_req && mdio_done;
  assign dly_run  = (state == S_RST_DLY) || (state == S_AN_DLY) || (state == S_LK_DLY);

  // access that the current state needs
  always_comb begin
    is_op   = 1'b1;
    op_wr   = 1'b0;
    op_reg  = REG_STAT;
    op_data = '0;
    case (state)
      S_SCAN_ST: op_reg = REG_STAT;
      S_SCAN_CT: op_reg = REG_CTRL;
      S_RST_WR:  begin op_wr = 1'b1; op_reg = REG_CTRL; op_data = 16'h0001 << B_RESET; end
      S_RST_RD:  op_reg = REG_CTRL;
      S_CFG_RD:  op_reg = cur_step.regno;
      S_CFG_WR:  begin op_wr = 1'b1; op_reg = cur_step.regno; op_data = rmw_val; end
      S_AN_RD:   op_reg = REG_STAT;
      S_LK_RD:   op_reg = REG_STAT;
      default:   is_op = 1'b0;
    endcase
  end

  // terminal failures
  always_comb begin
    abort      = 1'b0;
    abort_code = E_NONE;
    if (op_fin) begin
      case (state)
        S_SCAN_ST, S_SCAN_CT:
          if (!mdio_ok && cur_phy == LAST_PHY) begin abort = 1'b1; abort_code = E_NO_PHY; end
        S_RST_RD:
          if (!mdio_ok) begin abort = 1'b1; abort_code = E_RST_RD; end
          else if (mdio_rdata[B_RESET] && bud_last) begin abort = 1'b1; abort_code = E_RST_TO; end
        S_CFG_RD:
          if (!mdio_ok) begin abort = 1'b1; abort_code = E_CFG_RD; end
        S_AN_RD:
          if (!mdio_ok) begin abort = 1'b1; abort_code = E_AN_RD; end
          else if (!mdio_rdata[B_ANDONE] && bud_last) begin abort = 1'b1; abort_code = E_AN_TO; end
        S_LK_RD:
          if (!mdio_ok) begin abort = 1'b1; abort_code = E_LK_RD; end
          else if (!mdio_rdata[B_LINK] && bud_last) begin abort = 1'b1; abort_code = E_LK_TO; end
        default: abort = 1'b0;
      endcase
    end
  end

  assign bud_load = op_fin && ((state == S_RST_WR) ||
                    (state == S_CFG_WR && step_idx == LAST_STEP) ||
                    (state == S_AN_RD && mdio_ok && mdio_rdata[B_ANDONE]));
  assign bud_dec  = op_fin && mdio_ok && !bud_last &&
                    ((state == S_RST_RD && mdio_rdata[B_RESET]) ||
                     (state == S_AN_RD  && !mdio_rdata[B_ANDONE]) ||
                     (state == S_LK_RD  && !mdio_rdata[B_LINK]));

  pbu_tick_delay #(.STEP_TICKS(STEP_TICKS)) u_delay (
    .clk(clk), .rst(rst), .run(dly_run), .ms_tick(ms_tick), .expired(dly_exp)
  );

  pbu_budget #(.BUDGET_TICKS(BUDGET_TICKS), .STEP_TICKS(STEP_TICKS)) u_budget (
    .clk(clk), .rst(rst), .load(bud_load), .dec(bud_dec), .last(bud_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cur_phy    <= '0;
      step_idx   <= '0;
      rmw_val    <= '0;
      mdio_req   <= 1'b0;
      mdio_wr    <= 1'b0;
      mdio_phy   <= '0;
      mdio_reg   <= '0;
      mdio_wdata <= '0;
      phy_addr   <= '0;
      phy_found  <= 1'b0;
      reset_ok   <= 1'b0;
      aneg_done  <= 1'b0;
      link_up    <= 1'b0;
      timeout    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err_code   <= '0;
    end else begin
      if (is_op && !mdio_req) begin
        mdio_req   <= 1'b1;
        mdio_wr    <= op_wr;
        mdio_phy   <= cur_phy;
        mdio_reg   <= op_reg;
        mdio_wdata <= op_data;
      end
      if (op_fin)
        mdio_req <= 1'b0;

      if (abort) begin
        state    <= S_IDLE;
        busy     <= 1'b0;
        done     <= 1'b1;
        err_code <= abort_code;
        timeout  <= (abort_code == E_RST_TO) || (abort_code == E_AN_TO) ||
                    (abort_code == E_LK_TO);
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state     <= S_SCAN_ST;
            cur_phy   <= '0;
            phy_addr  <= '0;
            phy_found <= 1'b0;
            reset_ok  <= 1'b0;
            aneg_done <= 1'b0;
            link_up   <= 1'b0;
            timeout   <= 1'b0;
            err_code  <= '0;
            busy      <= 1'b1;
            done      <= 1'b0;
          end
          S_SCAN_ST: if (op_fin) begin
            if (mdio_ok) state <= S_SCAN_CT;
            else         cur_phy <= cur_phy + 1'b1;
          end
          S_SCAN_CT: if (op_fin) begin
            if (mdio_ok) begin
              phy_found <= 1'b1;
              phy_addr  <= cur_phy;
              state     <= S_RST_WR;
            end else begin
              cur_phy <= cur_phy + 1'b1;
              state   <= S_SCAN_ST;
            end
          end
          S_RST_WR:  if (op_fin) state <= S_RST_DLY;
          S_RST_DLY: if (dly_exp) state <= S_RST_RD;
          S_RST_RD: if (op_fin) begin
            if (!mdio_rdata[B_RESET]) begin
              step_idx <= '0;
              state    <= S_CFG_RD;
            end else
              state <= S_RST_DLY;
          end
          S_CFG_RD: if (op_fin) begin
            rmw_val <= (mdio_rdata & ~cur_step.clr_m) | cur_step.set_m;
            state   <= S_CFG_WR;
          end
          S_CFG_WR: if (op_fin) begin
            if (step_idx == '0) reset_ok <= 1'b1;
            if (step_idx == LAST_STEP) state <= S_AN_RD;
            else begin
              step_idx <= step_idx + 1'b1;
              state    <= S_CFG_RD;
            end
          end
          S_AN_RD: if (op_fin) begin
            if (mdio_rdata[B_ANDONE]) begin
              aneg_done <= 1'b1;
              state     <= S_LK_RD;
            end else
              state <= S_AN_DLY;
          end
          S_AN_DLY: if (dly_exp) state <= S_AN_RD;
          S_LK_RD: if (op_fin) begin
            if (mdio_rdata[B_LINK]) begin
              link_up <= 1'b1;
              busy    <= 1'b0;
              done    <= 1'b1;
              state   <= S_IDLE;
            end else
              state <= S_LK_DLY;
          end
          S_LK_DLY: if (dly_exp) state <= S_LK_RD;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
`timescale 1ns/1ps
module phy_bringup_chk #(
  parameter int PHY_SLOTS = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        mdio_req,
  input logic        mdio_wr,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        mdio_done,
  input logic        phy_found,
  input logic        reset_ok,
  input logic        aneg_done,
  input logic        link_up,
  input logic        timeout,
  input logic        busy,
  input logic        done,
  input logic [3:0]  err_code
);
  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    mdio_req && !mdio_done |=> mdio_req);

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (rst)
    mdio_req && !mdio_done |=> $stable({mdio_wr, mdio_phy, mdio_reg, mdio_wdata}));

  a_r10_drop_after_done: assert property (@(posedge clk) disable iff (rst)
    mdio_req && mdio_done |=> !mdio_req);

  a_r1_addr_range: assert property (@(posedge clk) disable iff (rst)
    mdio_req |-> (int'(mdio_phy) < PHY_SLOTS));

  a_r3_reset_value: assert property (@(posedge clk) disable iff (rst)
    mdio_req && mdio_wr && mdio_reg == 5'd0 && mdio_wdata[15] |-> mdio_wdata == 16'h8000);

  a_r7_adv_bits: assert property (@(posedge clk) disable iff (rst)
    mdio_req && mdio_wr && mdio_reg == 5'd4 |-> (mdio_wdata[8:5] == 4'hF));

  a_r11_flag_chain: assert property (@(posedge clk) disable iff (rst)
    (link_up |-> aneg_done) and (aneg_done |-> reset_ok) and (reset_ok |-> phy_found));

  a_r11_busy_done: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r4_timeout_code: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (err_code == 4'd3 || err_code == 4'd6 || err_code == 4'd8));

  a_r2_not_found: assert property (@(posedge clk) disable iff (rst)
    done && err_code == 4'd1 |-> !phy_found);
endmodule

bind phy_bringup phy_bringup_chk #(.PHY_SLOTS(PHY_SLOTS)) u_chk (.*);

// File: tb/tb_phy_bringup.sv
`timescale 1ns/1ps
module tb_phy_bringup;
  localparam int SLOTS  = 8;
  localparam int STEP   = 2;
  localparam int BUDGET = 6;
  localparam int POLLS  = (BUDGET + STEP - 1) / STEP;
  localparam int LAT    = 2;
  localparam int NEVER  = 1000;
  localparam logic [15:0] CTRL_INIT = 16'h3400;
  localparam logic [15:0] ADV_INIT  = 16'h0001;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ms_tick = 1'b0;
  logic mdio_req, mdio_wr, mdio_done, mdio_ok;
  logic [4:0] mdio_phy, mdio_reg, phy_addr;
  logic [15:0] mdio_wdata, mdio_rdata;
  logic phy_found, reset_ok, aneg_done, link_up, timeout, busy, done;
  logic [3:0] err_code;

  int n_chk = 0, n_bad = 0, cyc = 0, tick_cnt = 0;

  always #2.5 clk = ~clk;

  phy_bringup #(.PHY_SLOTS(SLOTS), .STEP_TICKS(STEP), .BUDGET_TICKS(BUDGET)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ms_tick <= (cyc % 4 == 3);
    if (ms_tick) tick_cnt <= tick_cnt + 1;
  end

  // model configuration (written by the stimulus only)
  int c_resp = 0, c_part = -1, c_hold = 0, c_an = 0, c_lk = 0, c_fstat = 0;
  bit c_frst = 0, c_fadv = 0, m_clear = 0;
  // model state (written by the model only)
  logic [15:0] m_ctrl, m_adv;
  int m_left, m_polls, m_sidx, m_pre, m_wn, m_viol, m_cnt, t_wr, t_poll;
  bit m_pend, m_restart, m_busy;
  logic [4:0]  wl_reg [8];
  logic [15:0] wl_dat [8];

  always @(posedge clk) begin
    mdio_done <= 1'b0;
    if (rst || m_clear) begin
      m_ctrl <= CTRL_INIT; m_adv <= ADV_INIT; m_left <= 0; m_polls <= 0;
      m_sidx <= 0; m_pre <= 0; m_wn <= 0; m_pend <= 0; m_restart <= 0;
      m_busy <= 0; m_cnt <= 0; t_wr <= 0; t_poll <= 0;
      if (rst) m_viol <= 0;
    end else if (m_busy) begin
      if (!mdio_req) begin m_viol <= m_viol + 1; m_busy <= 0; end
      else if (m_cnt > 0) m_cnt <= m_cnt - 1;
      else begin
        automatic bit full = (int'(mdio_phy) == c_resp);
        automatic bit ok = full || (int'(mdio_phy) == c_part && mdio_reg == 5'd1 && !mdio_wr);
        automatic logic [15:0] rd = 16'hFFFF;
        m_busy <= 0;
        mdio_done <= 1'b1;
        if (mdio_wr) begin
          ok = 1'b1;
          if (full) begin
            if (m_wn < 8) begin wl_reg[m_wn] <= mdio_reg; wl_dat[m_wn] <= mdio_wdata; end
            m_wn <= m_wn + 1;
            if (mdio_reg == 5'd0) begin
              if (mdio_wdata[15]) begin
                m_ctrl <= CTRL_INIT; m_pend <= 1; m_left <= c_hold; t_wr <= tick_cnt;
              end else begin
                m_ctrl <= mdio_wdata;
                if (mdio_wdata[9]) m_restart <= 1;
              end
            end else if (mdio_reg == 5'd4) m_adv <= mdio_wdata;
          end
        end else begin
          if (m_wn == 0) m_pre <= m_pre + 1;
          if (ok && mdio_reg == 5'd0) begin
            rd = m_ctrl;
            if (m_pend) begin
              m_polls <= m_polls + 1;
              if (m_polls == 0) t_poll <= tick_cnt;
              if (c_frst) ok = 1'b0;
              else if (m_left > 0) begin rd = m_ctrl | 16'h8000; m_left <= m_left - 1; end
              else m_pend <= 0;
            end
          end else if (ok && mdio_reg == 5'd1) begin
            rd = 16'h7809;
            if (m_restart) begin
              m_sidx <= m_sidx + 1;
              if (m_sidx + 1 == c_fstat) ok = 1'b0;
              if (m_sidx + 1 > c_an) rd = rd | 16'h0020;
              if (m_sidx + 1 > c_lk) rd = rd | 16'h0004;
            end
          end else if (ok && mdio_reg == 5'd4) begin
            rd = m_adv;
            if (c_fadv) ok = 1'b0;
          end
        end
        mdio_ok <= ok;
        mdio_rdata <= rd;
      end
    end else if (mdio_req && !mdio_done) begin
      m_busy <= 1; m_cnt <= LAT;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int resp, input int part, input int hold, input bit frst,
                     input bit fadv, input int an, input int lk, input int fstat);
    @(negedge clk);
    c_resp = resp; c_part = part; c_hold = hold; c_frst = frst; c_fadv = fadv;
    c_an = an; c_lk = lk; c_fstat = fstat; m_clear = 1;
    @(negedge clk);
    m_clear = 0;
  endtask

  task automatic run(input int extra_start_at);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R11", "busy after start", int'(busy), 1);
    chk("R11", "done cleared", int'(done), 0);
    for (int i = 0; !(done && !busy); i++) begin
      if (i == extra_start_at) start = 1;
      @(negedge clk);
      start = 0;
    end
  endtask

  task automatic expect_end(input string req, input int err, input int found, input int rok,
                            input int an, input int lk, input int to);
    chk(req, "err_code", int'(err_code), err);
    chk(req, "phy_found", int'(phy_found), found);
    chk(req, "reset_ok", int'(reset_ok), rok);
    chk(req, "aneg_done", int'(aneg_done), an);
    chk(req, "link_up", int'(link_up), lk);
    chk(req, "timeout", int'(timeout), to);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    mdio_ok = 0; mdio_rdata = '0;
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "done", int'(done), 0);
    chk("R12", "mdio_req", int'(mdio_req), 0);
    chk("R12", "flags", int'({phy_found, reset_ok, aneg_done, link_up, timeout}), 0);
    chk("R12", "err_code", int'(err_code), 0);
    rst = 0;

    // R1, R6, R7, R9: address sweep with a status-only responder just below
    for (int a = 0; a < SLOTS; a++) begin
      logic [15:0] w1, w2, w4, w5;
      cfg(a, a - 1, 0, 0, 0, 0, 0, 0);
      run(-1);
      expect_end("R9", 0, 1, 1, 1, 1, 0);
      chk("R1", "phy_addr", int'(phy_addr), a);
      chk("R1", "probe reads", m_pre, (a == 0) ? 2 : a + 3);
      w1 = CTRL_INIT & ~16'h0400;
      w2 = w1 & ~16'h1000;
      w4 = w2 | 16'h1000;
      w5 = w4 | 16'h0200;
      chk("R7", "write count", m_wn, 6);
      chk("R3", "reset write", int'(wl_dat[0]), 16'h8000);
      chk("R6", "isolate write", int'(wl_dat[1]), int'(w1));
      chk("R7", "aneg off write", int'(wl_dat[2]), int'(w2));
      chk("R7", "adv reg", int'(wl_reg[3]), 4);
      chk("R7", "adv write", int'(wl_dat[3]), int'(ADV_INIT | 16'h01E0));
      chk("R7", "aneg on write", int'(wl_dat[4]), int'(w4));
      chk("R7", "restart write", int'(wl_dat[5]), int'(w5));
    end

    // R2: nothing answers both reads
    cfg(-1, 3, 0, 0, 0, 0, 0, 0);
    run(-1);
    expect_end("R2", 1, 0, 0, 0, 0, 0);
    chk("R2", "probe reads", m_pre, SLOTS + 1);

    // R3, R4: reset poll budget edges
    for (int h = 0; h <= POLLS; h++) begin
      cfg(2, -1, h, 0, 0, 0, 0, 0);
      run(-1);
      chk("R4", "reset polls", m_polls, (h < POLLS) ? h + 1 : POLLS);
      if (h < POLLS) expect_end("R4", 0, 1, 1, 1, 1, 0);
      else           expect_end("R4", 3, 1, 0, 0, 0, 1);
      chk("R3", "ticks before first poll",
          int'((t_poll - t_wr) >= STEP && (t_poll - t_wr) <= STEP + 2), 1);
    end

    // R5: failed read during reset poll
    cfg(5, -1, 1, 1, 0, 0, 0, 0);
    run(-1);
    expect_end("R5", 2, 1, 0, 0, 0, 0);

    // R7: failed read during configuration
    cfg(1, -1, 0, 0, 1, 0, 0, 0);
    run(-1);
    expect_end("R7", 4, 1, 1, 0, 0, 0);

    // R8: negotiation wait edges
    for (int n = 0; n <= POLLS; n++) begin
      cfg(3, -1, 0, 0, 0, n, (n < POLLS) ? n : NEVER, 0);
      run(-1);
      if (n < POLLS) expect_end("R8", 0, 1, 1, 1, 1, 0);
      else begin
        expect_end("R8", 6, 1, 1, 0, 0, 1);
        chk("R8", "status polls", m_sidx, POLLS);
      end
    end
    cfg(3, -1, 0, 0, 0, 0, 0, 1);
    run(-1);
    expect_end("R8", 5, 1, 1, 0, 0, 0);

    // R9: link wait edges and read failure
    for (int l = 1; l <= POLLS + 1; l++) begin
      cfg(4, -1, 0, 0, 0, 0, l, 0);
      run(-1);
      if (l <= POLLS) expect_end("R9", 0, 1, 1, 1, 1, 0);
      else begin
        expect_end("R9", 8, 1, 1, 1, 0, 1);
        chk("R9", "status polls", m_sidx, 1 + POLLS);
      end
    end
    cfg(4, -1, 0, 0, 0, 0, 0, 2);
    run(-1);
    expect_end("R9", 7, 1, 1, 1, 0, 0);

    // R11: start during a run is ignored, and a new run clears old flags
    cfg(6, 2, 0, 0, 0, 0, 0, 0);
    run(30);
    expect_end("R11", 0, 1, 1, 1, 1, 0);
    chk("R11", "no rescan", m_pre, 6 + 3);
    chk("R11", "write count", m_wn, 6);

    chk("R10", "handshake violations", m_viol, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule